// File: doc/BRIEF.md
# Multiprocessor Bus Transaction Scheduler

This block connects a processor core to a shared split-transaction system bus. Snoop response data, read requests and victim write-backs each arrive on their own valid/ready port and are held in short buffers. Each cycle the block picks one of them to put on the bus under a fixed priority. There is one exception: when memory reports that it is saturated and both the read and victim buffers are full, a victim write goes ahead of a read. A request that finds its buffer empty, and that is granted the bus at once, goes straight to the bus in the same cycle without being stored. The block also counts the reads in flight. A counter over the four-beat return stream retires each read, and a new read is held back while the in-flight limit is reached.

Coherent transactions observed on the bus go into two queues: ten entries for cache snoops and three for translation-buffer snoops. The bus never rejects these transactions. When a queue is full and nothing leaves it in that cycle, the block raises a per-queue stall, and the bus side holds the transaction until the stall drops. The block takes the next snoop from a queue and sends it to the core as a single-cycle lightweight probe. The snoop stays at the head of its queue until the core answers. If the answer says that a cache state must change, a full-service request follows, and it is held until the core accepts it.

Top module: `bus_txn_sched`

## Requirements
- R1: When a snoop response is pending (buffered or offered at the port), an issue cycle (bus_req and bus_grant both high) carries it, with bus_kind = 1.
- R2: Without the override of R3, a pending read (bus_kind = 2) is issued ahead of a pending victim write (bus_kind = 3), unless the read limit of R5 holds it back.
- R3: When mem_rd_busy is high and both the read buffer and the victim buffer (two entries each) are full, the victim at the head of its buffer is issued before the read. Once either buffer has room, the normal order returns.
- R4: A request whose buffer is empty is issued in the same cycle it is offered, if it wins while bus_grant is high. It is not also stored, so it is issued only once.
- R5: rd_outstanding is 0 after reset and rises by one for each issued read. While it equals 6, no read is issued, and bus_req stays low if only reads are pending.
- R6: ret_beat pulses are counted in groups of four. rd_outstanding drops by one in the cycle after the fourth beat of a group and never after the first three.
- R7: The cache-snoop queue holds 10 entries and the translation-snoop queue holds 3. The head entry counts until its snoop is finished. cc_stall or tlb_stall is high exactly while a snoop is offered to a full queue that frees no slot in that cycle.
- R8: Every snoop accepted (offered while its stall is low) is probed exactly once, in arrival order within its queue. probe_tlb is 1 for translation snoops and 0 for cache snoops.
- R9: probe_valid is high for exactly one cycle per snoop, and no further probe starts before reply_valid answers it.
- R10: full_valid rises only after a reply with reply_change = 1. A reply with reply_change = 0 ends the snoop with no full request.
- R11: full_valid, full_addr and full_tlb stay steady until full_ready is high, and the snoop then leaves its queue.
- R12: When choosing the next snoop, the cache queue wins over the translation queue. A snoop already started is finished first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_rsp_valid | input | 1 | Snoop response data offered |
| snp_rsp_addr | input | ADDR_W | Snoop response line address |
| snp_rsp_ready | output | 1 | Snoop response accepted |
| rd_valid | input | 1 | Read request offered |
| rd_addr | input | ADDR_W | Read line address |
| rd_ready | output | 1 | Read request accepted |
| wb_valid | input | 1 | Victim write-back offered |
| wb_addr | input | ADDR_W | Victim line address |
| wb_ready | output | 1 | Victim accepted |
| mem_rd_busy | input | 1 | Memory cannot take new reads |
| bus_grant | input | 1 | Bus granted this cycle |
| bus_req | output | 1 | A transaction is ready to issue |
| bus_kind | output | 2 | 1 snoop data, 2 read, 3 victim |
| bus_addr | output | ADDR_W | Address of the issued transaction |
| ret_beat | input | 1 | One read-return data beat |
| rd_outstanding | output | clog2(MAX_RD+1) | Reads in flight |
| cc_snp_valid | input | 1 | Cache snoop arriving |
| cc_snp_addr | input | ADDR_W | Cache snoop address |
| cc_stall | output | 1 | Cache snoop must be held |
| tlb_snp_valid | input | 1 | Translation snoop arriving |
| tlb_snp_addr | input | ADDR_W | Translation snoop address |
| tlb_stall | output | 1 | Translation snoop must be held |
| probe_valid | output | 1 | Lightweight probe to core |
| probe_tlb | output | 1 | Probe is a translation snoop |
| probe_addr | output | ADDR_W | Probe address |
| reply_valid | input | 1 | Core answers the probe |
| reply_change | input | 1 | A state change is needed |
| full_valid | output | 1 | Full-service request to core |
| full_tlb | output | 1 | Full request is a translation snoop |
| full_addr | output | ADDR_W | Full request address |
| full_ready | input | 1 | Core accepts the full request |

## Verification
The hardest states to reach are the write-first override and the full-queue stall, because both need several buffers to be filled while nothing drains them. The bench fills them by holding bus_grant low while it loads two reads and two victims with mem_rd_busy high. It then opens the grant and checks that the victim at the head goes first. For the snoop queues, the core model stays silent, so the head remains in its queue. Twelve cache snoops then stall at the eleventh. Four translation snoops stall at the fourth, and a cache snoop slipped in behind three translation snoops must overtake the two that are still waiting.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_SNOOP = 2'd1,
    KIND_READ  = 2'd2,
    KIND_VICT  = 2'd3
  } txn_kind_e;

  typedef enum logic [1:0] {
    SF_IDLE  = 2'd0,
    SF_PROBE = 2'd1,
    SF_WAIT  = 2'd2,
    SF_FULL  = 2'd3
  } snp_state_e;
endpackage

// File: rtl/bts_fifo.sv
module bts_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/bts_issue.sv
module bts_issue
  import bts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_RD = 6,
  parameter int BEATS  = 4,
  parameter int SR_BUF = 2,
  parameter int RD_BUF = 2,
  parameter int WB_BUF = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sr_valid,
  input  logic [ADDR_W-1:0]             sr_addr,
  output logic                          sr_ready,
  input  logic                          rd_valid,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          rd_ready,
  input  logic                          wb_valid,
  input  logic [ADDR_W-1:0]             wb_addr,
  output logic                          wb_ready,
  input  logic                          mem_rd_busy,
  input  logic                          bus_grant,
  output logic                          bus_req,
  output logic [1:0]                    bus_kind,
  output logic [ADDR_W-1:0]             bus_addr,
  input  logic                          ret_beat,
  output logic [$clog2(MAX_RD+1)-1:0]   rd_outstanding
);
  localparam int CNT_W = $clog2(MAX_RD + 1);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [ADDR_W-1:0] sr_head, rd_head, wb_head;
  logic sr_empty, sr_full, rd_empty, rd_full, wb_empty, wb_full;
  logic sr_have, rd_have, wb_have, rd_ok, override, issue;
  logic sr_push, sr_pop, rd_push, rd_pop, wb_push, wb_pop;
  txn_kind_e sel;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BW-1:0]    beat_q, beat_d;
  logic             line_done, rd_issue;

  bts_fifo #(.W(ADDR_W), .DEPTH(SR_BUF)) u_sr_buf (
    .clk(clk), .rst_n(rst_n), .push(sr_push), .pop(sr_pop), .din(sr_addr),
    .dout(sr_head), .empty(sr_empty), .full(sr_full));
  bts_fifo #(.W(ADDR_W), .DEPTH(RD_BUF)) u_rd_buf (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .pop(rd_pop), .din(rd_addr),
    .dout(rd_head), .empty(rd_empty), .full(rd_full));
  bts_fifo #(.W(ADDR_W), .DEPTH(WB_BUF)) u_wb_buf (
    .clk(clk), .rst_n(rst_n), .push(wb_push), .pop(wb_pop), .din(wb_addr),
    .dout(wb_head), .empty(wb_empty), .full(wb_full));

  // A class has a candidate if its buffer holds one or the port offers one.
  assign sr_have  = !sr_empty || sr_valid;
  assign rd_have  = !rd_empty || rd_valid;
  assign wb_have  = !wb_empty || wb_valid;
  assign rd_ok    = (cnt_q < CNT_W'(MAX_RD));
  assign override = mem_rd_busy && rd_full && wb_full;

  always_comb begin
    sel = KIND_NONE;
    if (sr_have)                  sel = KIND_SNOOP;
    else if (override && wb_have) sel = KIND_VICT;
    else if (rd_have && rd_ok)    sel = KIND_READ;
    else if (wb_have)             sel = KIND_VICT;
  end

  always_comb begin
    unique case (sel)
      KIND_SNOOP: bus_addr = sr_empty ? sr_addr : sr_head;
      KIND_READ:  bus_addr = rd_empty ? rd_addr : rd_head;
      KIND_VICT:  bus_addr = wb_empty ? wb_addr : wb_head;
      default:    bus_addr = '0;
    endcase
  end

  assign bus_req  = (sel != KIND_NONE);
  assign bus_kind = sel;
  assign issue    = bus_req && bus_grant;

  // Pop the head on issue; store an offer unless it bypassed an empty buffer.
  assign sr_pop  = issue && (sel == KIND_SNOOP) && !sr_empty;
  assign rd_pop  = issue && (sel == KIND_READ)  && !rd_empty;
  assign wb_pop  = issue && (sel == KIND_VICT)  && !wb_empty;
  assign sr_push = sr_valid && !sr_full && !(issue && (sel == KIND_SNOOP) && sr_empty);
  assign rd_push = rd_valid && !rd_full && !(issue && (sel == KIND_READ)  && rd_empty);
  assign wb_push = wb_valid && !wb_full && !(issue && (sel == KIND_VICT)  && wb_empty);
  assign sr_ready = !sr_full;
  assign rd_ready = !rd_full;
  assign wb_ready = !wb_full;

  // In-flight read count, retired on the last beat of each return.
  assign rd_issue  = issue && (sel == KIND_READ);
  assign line_done = ret_beat && (beat_q == BW'(BEATS - 1));

  always_comb begin
    beat_d = beat_q;
    if (ret_beat) beat_d = line_done ? '0 : beat_q + 1'b1;
    unique case ({rd_issue, line_done})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
    end
  end

  assign rd_outstanding = cnt_q;
endmodule

// File: rtl/bts_snoop_fwd.sv
module bts_snoop_fwd
  import bts_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CC_DEPTH  = 10,
  parameter int TLB_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cc_valid,
  input  logic [ADDR_W-1:0] cc_addr,
  output logic              cc_stall,
  input  logic              tlb_valid,
  input  logic [ADDR_W-1:0] tlb_addr,
  output logic              tlb_stall,
  output logic              probe_valid,
  output logic              probe_tlb,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              reply_valid,
  input  logic              reply_change,
  output logic              full_valid,
  output logic              full_tlb,
  output logic [ADDR_W-1:0] full_addr,
  input  logic              full_ready
);
  snp_state_e st_q, st_d;
  logic sel_q, sel_d, done;
  logic cc_push, cc_pop, cc_empty, cc_full;
  logic tlb_push, tlb_pop, tlb_empty, tlb_full;
  logic [ADDR_W-1:0] cc_head, tlb_head, head;

  bts_fifo #(.W(ADDR_W), .DEPTH(CC_DEPTH)) u_cc_q (
    .clk(clk), .rst_n(rst_n), .push(cc_push), .pop(cc_pop), .din(cc_addr),
    .dout(cc_head), .empty(cc_empty), .full(cc_full));
  bts_fifo #(.W(ADDR_W), .DEPTH(TLB_DEPTH)) u_tlb_q (
    .clk(clk), .rst_n(rst_n), .push(tlb_push), .pop(tlb_pop), .din(tlb_addr),
    .dout(tlb_head), .empty(tlb_empty), .full(tlb_full));

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    done  = 1'b0;
    unique case (st_q)
      SF_IDLE: begin
        if (!cc_empty)       begin sel_d = 1'b0; st_d = SF_PROBE; end
        else if (!tlb_empty) begin sel_d = 1'b1; st_d = SF_PROBE; end
      end
      SF_PROBE: st_d = SF_WAIT;
      SF_WAIT: begin
        if (reply_valid) begin
          if (reply_change) st_d = SF_FULL;
          else begin done = 1'b1; st_d = SF_IDLE; end
        end
      end
      SF_FULL: begin
        if (full_ready) begin done = 1'b1; st_d = SF_IDLE; end
      end
      default: st_d = SF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SF_IDLE;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
    end
  end

  // The head stays queued until its snoop is finished; a pop frees a slot at once.
  assign cc_pop    = done && !sel_q;
  assign tlb_pop   = done && sel_q;
  assign cc_push   = cc_valid  && (!cc_full  || cc_pop);
  assign tlb_push  = tlb_valid && (!tlb_full || tlb_pop);
  assign cc_stall  = cc_valid  && cc_full  && !cc_pop;
  assign tlb_stall = tlb_valid && tlb_full && !tlb_pop;

  assign head        = sel_q ? tlb_head : cc_head;
  assign probe_valid = (st_q == SF_PROBE);
  assign probe_tlb   = sel_q;
  assign probe_addr  = head;
  assign full_valid  = (st_q == SF_FULL);
  assign full_tlb    = sel_q;
  assign full_addr   = head;
endmodule

// File: rtl/bus_txn_sched.sv
module bus_txn_sched #(
  parameter int ADDR_W    = 32,
  parameter int MAX_RD    = 6,
  parameter int BEATS     = 4,
  parameter int SR_BUF    = 2,
  parameter int RD_BUF    = 2,
  parameter int WB_BUF    = 2,
  parameter int CC_DEPTH  = 10,
  parameter int TLB_DEPTH = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        snp_rsp_valid,
  input  logic [ADDR_W-1:0]           snp_rsp_addr,
  output logic                        snp_rsp_ready,
  input  logic                        rd_valid,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic                        rd_ready,
  input  logic                        wb_valid,
  input  logic [ADDR_W-1:0]           wb_addr,
  output logic                        wb_ready,
  input  logic                        mem_rd_busy,
  input  logic                        bus_grant,
  output logic                        bus_req,
  output logic [1:0]                  bus_kind,
  output logic [ADDR_W-1:0]           bus_addr,
  input  logic                        ret_beat,
  output logic [$clog2(MAX_RD+1)-1:0] rd_outstanding,
  input  logic                        cc_snp_valid,
  input  logic [ADDR_W-1:0]           cc_snp_addr,
  output logic                        cc_stall,
  input  logic                        tlb_snp_valid,
  input  logic [ADDR_W-1:0]           tlb_snp_addr,
  output logic                        tlb_stall,
  output logic                        probe_valid,
  output logic                        probe_tlb,
  output logic [ADDR_W-1:0]           probe_addr,
  input  logic                        reply_valid,
  input  logic                        reply_change,
  output logic                        full_valid,
  output logic                        full_tlb,
  output logic [ADDR_W-1:0]           full_addr,
  input  logic                        full_ready
);
  bts_issue #(
    .ADDR_W(ADDR_W), .MAX_RD(MAX_RD), .BEATS(BEATS),
    .SR_BUF(SR_BUF), .RD_BUF(RD_BUF), .WB_BUF(WB_BUF)
  ) u_issue (
    .clk(clk), .rst_n(rst_n),
    .sr_valid(snp_rsp_valid), .sr_addr(snp_rsp_addr), .sr_ready(snp_rsp_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
    .mem_rd_busy(mem_rd_busy), .bus_grant(bus_grant),
    .bus_req(bus_req), .bus_kind(bus_kind), .bus_addr(bus_addr),
    .ret_beat(ret_beat), .rd_outstanding(rd_outstanding));

  bts_snoop_fwd #(
    .ADDR_W(ADDR_W), .CC_DEPTH(CC_DEPTH), .TLB_DEPTH(TLB_DEPTH)
  ) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .cc_valid(cc_snp_valid), .cc_addr(cc_snp_addr), .cc_stall(cc_stall),
    .tlb_valid(tlb_snp_valid), .tlb_addr(tlb_snp_addr), .tlb_stall(tlb_stall),
    .probe_valid(probe_valid), .probe_tlb(probe_tlb), .probe_addr(probe_addr),
    .reply_valid(reply_valid), .reply_change(reply_change),
    .full_valid(full_valid), .full_tlb(full_tlb), .full_addr(full_addr),
    .full_ready(full_ready));
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int MAX_RD = 6,
  parameter int ADDR_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        snp_rsp_valid,
  input logic                        rd_valid,
  input logic                        mem_rd_busy,
  input logic                        bus_grant,
  input logic                        bus_req,
  input logic [1:0]                  bus_kind,
  input logic                        ret_beat,
  input logic [$clog2(MAX_RD+1)-1:0] rd_outstanding,
  input logic                        probe_valid,
  input logic                        reply_valid,
  input logic                        reply_change,
  input logic                        full_valid,
  input logic                        full_tlb,
  input logic [ADDR_W-1:0]           full_addr,
  input logic                        full_ready
);
  localparam int CW = $clog2(MAX_RD + 1);

  a_r1_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && snp_rsp_valid) |-> (bus_kind == 2'd1));

  a_r2_read_before_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && bus_kind == 2'd3 && rd_valid && !mem_rd_busy)
      |-> (rd_outstanding == CW'(MAX_RD)));

  a_r5_read_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_grant && bus_kind == 2'd2) |-> (rd_outstanding < CW'(MAX_RD)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_outstanding <= CW'(MAX_RD));

  a_r6_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_beat && !(bus_req && bus_grant && bus_kind == 2'd2)) |=> $stable(rd_outstanding));

  a_r9_probe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |=> !probe_valid);

  a_r10_full_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_valid) |-> $past(reply_valid && reply_change));

  a_r11_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full_valid && !full_ready) |=> (full_valid && $stable(full_addr) && $stable(full_tlb)));
endmodule

bind bus_txn_sched bts_checker #(.MAX_RD(MAX_RD), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_bus_txn_sched.sv
module test_bus_txn_sched;
  logic clk, rst_n;
  logic snp_rsp_valid, rd_valid, wb_valid, mem_rd_busy, bus_grant, ret_beat;
  logic [31:0] snp_rsp_addr, rd_addr, wb_addr, cc_snp_addr, tlb_snp_addr;
  logic snp_rsp_ready, rd_ready, wb_ready, bus_req;
  logic [1:0] bus_kind;
  logic [31:0] bus_addr, probe_addr, full_addr;
  logic [2:0] rd_outstanding;
  logic cc_snp_valid, tlb_snp_valid, cc_stall, tlb_stall;
  logic probe_valid, probe_tlb, reply_valid, reply_change;
  logic full_valid, full_tlb, full_ready;

  int n_chk = 0, n_bad = 0;
  logic [33:0] exp_bus[$];
  logic [32:0] exp_probe[$];
  logic [32:0] exp_full[$];
  bit core_en = 0;
  int probes_seen = 0, fulls_seen = 0;
  int stall_idx = -1;

  bus_txn_sched i_bus_txn_sched (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ret_line();
    for (int b = 0; b < 4; b++) begin ret_beat = 1; cyc(1); end
    ret_beat = 0;
  endtask

  task automatic push_cc(logic [31:0] a, int idx);
    cc_snp_valid = 1; cc_snp_addr = a;
    do begin
      @(negedge clk);
      if (cc_stall && stall_idx < 0) stall_idx = idx;
    end while (cc_stall);
    cyc(1);
    cc_snp_valid = 0;
  endtask

  task automatic push_tlb(logic [31:0] a, int idx);
    tlb_snp_valid = 1; tlb_snp_addr = a;
    do begin
      @(negedge clk);
      if (tlb_stall && stall_idx < 0) stall_idx = idx;
    end while (tlb_stall);
    cyc(1);
    tlb_snp_valid = 0;
  endtask

  // Monitor: every issue cycle pops the next expected bus transaction.
  initial begin : bus_mon
    logic [33:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req && bus_grant) begin
        if (exp_bus.size() == 0)
          check(0, "R1/R2/R3 unexpected issue", {bus_kind, bus_addr}, 0);
        else begin
          e = exp_bus.pop_front();
          check({bus_kind, bus_addr} == e, "R1/R2/R3/R4/R5 issue order", {bus_kind, bus_addr}, e);
        end
      end
    end
  end

  // Core model: answers probes, checks them against the expected stream.
  initial begin : core_model
    logic [31:0] a;
    logic t;
    logic [32:0] e;
    reply_valid = 0; reply_change = 0; full_ready = 0;
    forever begin
      @(negedge clk);
      if (rst_n && probe_valid) begin
        a = probe_addr; t = probe_tlb; probes_seen++;
        if (exp_probe.size() == 0) check(0, "R8 unexpected probe", {t, a}, 0);
        else begin
          e = exp_probe.pop_front();
          check({t, a} == e, "R8 R12 probe order", {t, a}, e);
        end
        @(negedge clk);
        check(!probe_valid, "R9 probe lasts one cycle", probe_valid, 0);
        while (!core_en) begin
          @(negedge clk);
          check(!probe_valid, "R9 no new probe before reply", probe_valid, 0);
        end
        @(posedge clk); #1 reply_valid = 1; reply_change = a[0];
        @(posedge clk); #1 reply_valid = 0;
        if (a[0]) begin
          @(negedge clk);
          check(full_valid, "R10 full follows change", full_valid, 1);
          @(posedge clk); #1 full_ready = 1;
          @(negedge clk);
          check(full_valid, "R11 full held until ready", full_valid, 1);
          if (exp_full.size() == 0) check(0, "R10 unexpected full", {full_tlb, full_addr}, 0);
          else begin
            e = exp_full.pop_front();
            check({full_tlb, full_addr} == e, "R11 full address", {full_tlb, full_addr}, e);
          end
          fulls_seen++;
          @(posedge clk); #1 full_ready = 0;
        end else begin
          @(negedge clk);
          check(!full_valid, "R10 no full without change", full_valid, 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin : main
    rst_n = 0;
    snp_rsp_valid = 0; rd_valid = 0; wb_valid = 0; mem_rd_busy = 0;
    bus_grant = 0; ret_beat = 0; cc_snp_valid = 0; tlb_snp_valid = 0;
    snp_rsp_addr = 0; rd_addr = 0; wb_addr = 0; cc_snp_addr = 0; tlb_snp_addr = 0;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    check(!bus_req, "R5 reset bus_req", bus_req, 0);
    check(rd_outstanding == 0, "R5 reset count", rd_outstanding, 0);
    check(!probe_valid && !full_valid, "R9 reset probe", probe_valid, 0);
    cyc(1);

    // R4: bypass of an empty buffer in the same cycle
    bus_grant = 1; rd_valid = 1; rd_addr = 32'h1000;
    exp_bus.push_back({2'd2, 32'h1000});
    cyc(1);
    rd_valid = 0;
    @(negedge clk);
    check(!bus_req, "R4 bypassed read not stored", bus_req, 0);
    check(rd_outstanding == 1, "R5 count after one read", rd_outstanding, 1);
    cyc(1);

    // R1, R2: three classes loaded together, then granted
    bus_grant = 0;
    snp_rsp_valid = 1; snp_rsp_addr = 32'h0500;
    rd_valid = 1;      rd_addr = 32'h1100;
    wb_valid = 1;      wb_addr = 32'h1200;
    exp_bus.push_back({2'd1, 32'h0500});
    exp_bus.push_back({2'd2, 32'h1100});
    exp_bus.push_back({2'd3, 32'h1200});
    cyc(1);
    snp_rsp_valid = 0; rd_valid = 0; wb_valid = 0;
    bus_grant = 1;
    cyc(4);
    bus_grant = 0;
    check(exp_bus.size() == 0, "R1 R2 all issued", exp_bus.size(), 0);
    check(rd_outstanding == 2, "R5 count two", rd_outstanding, 2);

    // R6: retire on the fourth beat only
    ret_line();
    @(negedge clk);
    check(rd_outstanding == 1, "R6 one line retired", rd_outstanding, 1);
    cyc(1);
    for (int b = 0; b < 3; b++) begin ret_beat = 1; cyc(1); end
    ret_beat = 0;
    @(negedge clk);
    check(rd_outstanding == 1, "R6 three beats do not retire", rd_outstanding, 1);
    cyc(1);
    ret_beat = 1; cyc(1); ret_beat = 0;
    @(negedge clk);
    check(rd_outstanding == 0, "R6 fourth beat retires", rd_outstanding, 0);
    cyc(1);

    // R5: six reads in flight, seventh held
    bus_grant = 1;
    for (int i = 0; i < 6; i++) begin
      rd_valid = 1; rd_addr = 32'h2000 + 32'(i * 32);
      exp_bus.push_back({2'd2, rd_addr});
      cyc(1);
    end
    rd_valid = 1; rd_addr = 32'h3000;
    @(negedge clk);
    check(!bus_req, "R5 seventh read held", bus_req, 0);
    cyc(1);
    rd_valid = 0;
    @(negedge clk);
    check(rd_outstanding == 6, "R5 limit reached", rd_outstanding, 6);
    exp_bus.push_back({2'd2, 32'h3000});
    cyc(1);
    ret_line();
    cyc(2);
    check(exp_bus.size() == 0, "R5 held read issued after retire", exp_bus.size(), 0);
    @(negedge clk);
    check(rd_outstanding == 6, "R5 count back at limit", rd_outstanding, 6);
    cyc(1);
    for (int i = 0; i < 6; i++) ret_line();
    @(negedge clk);
    check(rd_outstanding == 0, "R6 all retired", rd_outstanding, 0);
    cyc(1);

    // R3: memory saturated, both buffers full -> victim first
    bus_grant = 0; mem_rd_busy = 1;
    rd_valid = 1; rd_addr = 32'h4000; wb_valid = 1; wb_addr = 32'h5000;
    cyc(1);
    rd_addr = 32'h4020; wb_addr = 32'h5020;
    cyc(1);
    rd_valid = 0; wb_valid = 0;
    @(negedge clk);
    check(!rd_ready && !wb_ready, "R3 both buffers full", {rd_ready, wb_ready}, 0);
    exp_bus.push_back({2'd3, 32'h5000});
    exp_bus.push_back({2'd2, 32'h4000});
    exp_bus.push_back({2'd2, 32'h4020});
    exp_bus.push_back({2'd3, 32'h5020});
    cyc(1);
    bus_grant = 1;
    cyc(5);
    bus_grant = 0; mem_rd_busy = 0;
    check(exp_bus.size() == 0, "R3 override order complete", exp_bus.size(), 0);
    ret_line(); ret_line();

    // R7, R8: twelve cache snoops while the core is silent
    for (int i = 0; i < 12; i++) begin
      exp_probe.push_back({1'b0, 32'h100 + 32'(i)});
      if (i % 2 == 1) exp_full.push_back({1'b0, 32'h100 + 32'(i)});
    end
    stall_idx = -1;
    fork
      for (int i = 0; i < 12; i++) push_cc(32'h100 + 32'(i), i);
      begin
        cyc(30);
        check(stall_idx == 10, "R7 cache queue stalls at eleventh", stall_idx, 10);
        core_en = 1;
      end
    join
    for (int w = 0; w < 400 && (exp_probe.size() != 0 || exp_full.size() != 0); w++) cyc(1);
    cyc(4);
    check(probes_seen == 12, "R8 every cache snoop probed", probes_seen, 12);
    check(fulls_seen == 6, "R10 full only on change", fulls_seen, 6);

    // R7, R12: translation queue depth and cache-first choice
    core_en = 0;
    probes_seen = 0; fulls_seen = 0; stall_idx = -1;
    exp_probe.push_back({1'b1, 32'h200});
    exp_probe.push_back({1'b0, 32'h301});
    exp_probe.push_back({1'b1, 32'h202});
    exp_probe.push_back({1'b1, 32'h204});
    exp_probe.push_back({1'b1, 32'h206});
    exp_full.push_back({1'b0, 32'h301});
    push_tlb(32'h200, 0);
    push_tlb(32'h202, 1);
    push_tlb(32'h204, 2);
    push_cc(32'h301, 9);
    fork
      push_tlb(32'h206, 3);
      begin
        cyc(6);
        check(stall_idx == 3, "R7 translation queue stalls at fourth", stall_idx, 3);
        core_en = 1;
      end
    join
    for (int w = 0; w < 400 && (exp_probe.size() != 0 || exp_full.size() != 0); w++) cyc(1);
    cyc(4);
    check(probes_seen == 5, "R8 R12 all five probed", probes_seen, 5);
    check(fulls_seen == 1, "R10 one full request", fulls_seen, 1);
    summary();
  end
endmodule